// File: doc/BRIEF.md
# Colour Subcarrier Phase Synthesizer

This block produces the running colour subcarrier phase for a video encoder clocked at 27 MHz. A 32-bit phase register advances by a tuning word on every clock and wraps modulo 2^32. Its top bits can address a sine table further down the pipe. The tuning word is 2^32 times the number of subcarrier periods per line divided by the number of clocks per line, rounded to the nearest integer. For NTSC (227.5 periods in 1716 clocks) this gives 0x21F07C1F, which is also the value after reset.

Software loads the tuning word one byte at a time through a small write port, in ascending byte order. The word only goes live when the top byte lands, so the accumulator never runs on a half-written value.

In lock mode an external decoder sends a serial frame. The frame carries a 22-bit increment, a line-sequence flag and a phase-reset flag. The increment, joined with the ten low bits of the programmed word, replaces the step, and the reset flag restarts the phase at zero. In PAL the sequence flag drives the line-inversion output.

Top module: `sc_phase_synth`

## Requirements
- R1: After reset the phase output is 0, the line-inversion output is 0, and the active tuning word is 0x21F07C1F.
- R2: With lock mode off, the phase advances by the active tuning word on every clock, modulo 2^32.
- R3: Byte address 0 holds bits 7:0 of the word, 1 holds 15:8, 2 holds 23:16 and 3 holds 31:24. The staged word becomes active in the clock edge that accepts the in-order write to address 3, so the phase uses it from the next edge on.
- R4: A write to an address other than the one expected restarts staging and leaves the active word unchanged. If that write is to address 0, it is kept as the first byte of a new sequence.
- R5: With lock mode on, a start pulse opens a frame. The next 33 cycles with the bit-valid input high each shift in one bit, first bit first. Counting from the first bit (index 0), bits 0..3 are spare, bits 4..25 are the increment (most significant bit first), bit 26 is the sequence flag, bit 27 is the reset flag, and bits 28..32 are spare. A bit offered in the same cycle as a start pulse is dropped.
- R6: From the edge after the one that takes the 33rd bit, while lock mode stays on, the step becomes {increment[21:0], active word[9:0]}.
- R7: A frame with the reset flag set loads phase 0 on the edge after its 33rd bit, instead of adding the step.
- R8: In PAL mode a completed frame copies its sequence flag to the line-inversion output (1 = inverted line). In NTSC mode frames leave that output unchanged.
- R9: The values of the spare frame bits have no effect on any output.
- R10: A frame that is cut short by a new start pulse has no effect. Frames are ignored while lock mode is off. Turning lock mode off returns the step to the programmed word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 27 MHz clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | 2 | Byte index of the tuning word |
| wr_data | input | 8 | Byte value |
| lock_en | input | 1 | Lock mode enable |
| pal_mode | input | 1 | 1 = PAL line-sequence handling, 0 = NTSC |
| lk_start | input | 1 | Start pulse of a serial lock frame |
| lk_valid | input | 1 | Serial bit qualifier |
| lk_bit | input | 1 | Serial frame data |
| phase | output | 32 | Current subcarrier phase |
| line_inv | output | 1 | PAL line-inversion flag |

## Verification
Two events can fall on the same clock edge: the commit of byte 3, and the first use of a freshly received lock increment. On that edge the step takes its ten low bits from the word that was active before the commit, and the new low bits take over one edge later. The bench arranges this by issuing the byte-3 write in the cycle right after a frame's last bit. It does this both with and without the reset flag. A cycle-accurate model in the bench, built from the requirements, judges the phase on every cycle around the collision.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int unsigned SC_WORD_W  = 32;
  localparam int unsigned SC_BYTE_W  = 8;
  localparam int unsigned SC_INC_W   = 22;
  localparam int unsigned SC_SPARE_A = 4;
  localparam int unsigned SC_SPARE_B = 5;
  localparam logic [SC_WORD_W-1:0] SC_NTSC_WORD = 32'h21F0_7C1F;

  function automatic int unsigned sc_frame_len(int unsigned inc_w, int unsigned sa, int unsigned sb);
    return sa + inc_w + 2 + sb;
  endfunction
endpackage

// File: rtl/sc_tune_stage.sv
module sc_tune_stage #(
  parameter int unsigned WORD_W = sc_pkg::SC_WORD_W,
  parameter int unsigned BYTE_W = sc_pkg::SC_BYTE_W,
  parameter logic [WORD_W-1:0] RESET_WORD = sc_pkg::SC_NTSC_WORD,
  localparam int unsigned NBYTES = WORD_W / BYTE_W,
  localparam int unsigned IDX_W  = $clog2(NBYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_addr_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  output logic [WORD_W-1:0] word_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NBYTES - 1);

  logic [IDX_W-1:0]  exp_q, exp_d;
  logic [WORD_W-1:0] word_q;
  logic [WORD_W-1:0] assembled;
  logic              in_order;
  logic              commit_en;
  logic [NBYTES-2:0] stage_en;
  logic [BYTE_W-1:0] stage_q [NBYTES-1];

  assign in_order  = wr_en_i && (wr_addr_i == exp_q);
  assign commit_en = in_order && (exp_q == LAST);

  always_comb begin
    exp_d = exp_q;
    if (wr_en_i) begin
      if (wr_addr_i == exp_q) begin
        exp_d = (exp_q == LAST) ? '0 : exp_q + 1'b1;
      end else begin
        exp_d = (wr_addr_i == '0) ? IDX_W'(1) : '0;
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NBYTES - 1; i++) begin
      stage_en[i] = in_order && (exp_q == IDX_W'(i));
    end
    if (wr_en_i && !in_order && (wr_addr_i == '0)) stage_en[0] = 1'b1;
  end

  for (genvar g = 0; g < NBYTES - 1; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          stage_q[g] <= '0;
      else if (stage_en[g]) stage_q[g] <= wr_data_i;
    end
    assign assembled[g*BYTE_W +: BYTE_W] = stage_q[g];
  end
  assign assembled[WORD_W-1 -: BYTE_W] = wr_data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) exp_q <= '0;
    else         exp_q <= exp_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        word_q <= RESET_WORD;
    else if (commit_en) word_q <= assembled;
  end

  assign word_o = word_q;

  // R3: the active word moves only on an in-order write of the top byte
  a_r3_hold_until_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && wr_addr_i == LAST && exp_q == LAST) |=> $stable(word_q));
  // R4: a stray write to a non-zero address sends staging back to byte 0
  a_r4_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i != exp_q && wr_addr_i != '0) |=> (exp_q == '0));
endmodule

// File: rtl/sc_lock_rx.sv
module sc_lock_rx #(
  parameter int unsigned INC_W   = sc_pkg::SC_INC_W,
  parameter int unsigned SPARE_A = sc_pkg::SC_SPARE_A,
  parameter int unsigned SPARE_B = sc_pkg::SC_SPARE_B,
  localparam int unsigned FRAME_LEN = sc_pkg::sc_frame_len(INC_W, SPARE_A, SPARE_B),
  localparam int unsigned CNT_W     = $clog2(FRAME_LEN + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             start_i,
  input  logic             valid_i,
  input  logic             bit_i,
  output logic             done_o,
  output logic [INC_W-1:0] inc_o,
  output logic             seq_o,
  output logic             rst_o
);
  logic                 busy_q, busy_d;
  logic [CNT_W-1:0]     cnt_q, cnt_d;
  logic [FRAME_LEN-2:0] sh_q, sh_d;
  logic [FRAME_LEN-1:0] full;
  logic                 take, last;
  logic                 done_q, done_d;
  logic [INC_W-1:0]     inc_q;
  logic                 seq_q, rstf_q;

  assign full = {sh_q, bit_i};
  assign take = enable_i && !start_i && busy_q && valid_i;
  assign last = take && (cnt_q == CNT_W'(FRAME_LEN - 1));

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    sh_d   = sh_q;
    done_d = 1'b0;
    if (!enable_i) begin
      busy_d = 1'b0;
    end else if (start_i) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end else if (take) begin
      sh_d  = full[FRAME_LEN-2:0];
      cnt_d = cnt_q + 1'b1;
      if (last) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      sh_q   <= '0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      sh_q   <= sh_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      inc_q  <= '0;
      seq_q  <= 1'b0;
      rstf_q <= 1'b0;
    end else if (last) begin
      inc_q  <= full[FRAME_LEN-1-SPARE_A -: INC_W];
      seq_q  <= full[SPARE_B+1];
      rstf_q <= full[SPARE_B];
    end
  end

  assign done_o = done_q;
  assign inc_o  = inc_q;
  assign seq_o  = seq_q;
  assign rst_o  = rstf_q;

  // R5: a frame needs many bits, so completions never come back to back
  a_r5_done_spaced: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  // R10: with lock mode off no frame can complete
  a_r10_off_no_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> !done_q);
endmodule

// File: rtl/sc_phase_acc.sv
module sc_phase_acc #(
  parameter int unsigned WORD_W = sc_pkg::SC_WORD_W,
  parameter int unsigned INC_W  = sc_pkg::SC_INC_W,
  localparam int unsigned LOW_W = WORD_W - INC_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lock_en_i,
  input  logic              pal_i,
  input  logic [WORD_W-1:0] tune_word_i,
  input  logic              frm_done_i,
  input  logic [INC_W-1:0]  frm_inc_i,
  input  logic              frm_seq_i,
  input  logic              frm_rst_i,
  output logic [WORD_W-1:0] phase_o,
  output logic              line_inv_o
);
  logic [WORD_W-1:0] phase_q, phase_d;
  logic [WORD_W-1:0] step_word;
  logic [INC_W-1:0]  inc_q, inc_sel;
  logic              ok_q, ok_d;
  logic              inv_q, inv_d;
  logic              use_lock, frm_hit, inc_en;

  assign frm_hit  = lock_en_i && frm_done_i;
  assign use_lock = lock_en_i && (ok_q || frm_done_i);
  assign inc_sel  = frm_done_i ? frm_inc_i : inc_q;
  assign inc_en   = frm_hit;

  always_comb begin
    step_word = use_lock ? {inc_sel, tune_word_i[LOW_W-1:0]} : tune_word_i;
    phase_d   = (frm_hit && frm_rst_i) ? '0 : phase_q + step_word;
    ok_d      = use_lock;
    inv_d     = (frm_hit && pal_i) ? frm_seq_i : inv_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      ok_q    <= 1'b0;
      inv_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      ok_q    <= ok_d;
      inv_q   <= inv_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     inc_q <= '0;
    else if (inc_en) inc_q <= frm_inc_i;
  end

  assign phase_o    = phase_q;
  assign line_inv_o = inv_q;

  // R2: free-running add of the programmed word when lock mode is off
  a_r2_free_add: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !$past(lock_en_i)) |-> (phase_q == $past(phase_q) + $past(tune_word_i)));
  // R7: a frame with its reset flag restarts the phase at zero
  a_r7_reset_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_en_i && frm_done_i && frm_rst_i) |=> (phase_q == '0));
  // R8: the inversion flag only moves on a completed frame in PAL mode
  a_r8_inv_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(inv_q) |-> $past(lock_en_i && frm_done_i && pal_i));
endmodule

// File: rtl/sc_phase_synth.sv
module sc_phase_synth #(
  parameter int unsigned WORD_W = sc_pkg::SC_WORD_W,
  parameter int unsigned BYTE_W = sc_pkg::SC_BYTE_W,
  parameter int unsigned INC_W  = sc_pkg::SC_INC_W,
  localparam int unsigned IDX_W = $clog2(WORD_W / BYTE_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              lock_en,
  input  logic              pal_mode,
  input  logic              lk_start,
  input  logic              lk_valid,
  input  logic              lk_bit,
  output logic [WORD_W-1:0] phase,
  output logic              line_inv
);
  logic             rs1_q, rs2_q, rst_sync_n;
  logic [WORD_W-1:0] tune_word;
  logic             frm_done, frm_seq, frm_rst;
  logic [INC_W-1:0] frm_inc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign rst_sync_n = rs2_q;

  sc_tune_stage #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_stage (
    .clk_i     (clk),
    .rst_ni    (rst_sync_n),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .word_o    (tune_word)
  );

  sc_lock_rx #(.INC_W(INC_W)) u_rx (
    .clk_i    (clk),
    .rst_ni   (rst_sync_n),
    .enable_i (lock_en),
    .start_i  (lk_start),
    .valid_i  (lk_valid),
    .bit_i    (lk_bit),
    .done_o   (frm_done),
    .inc_o    (frm_inc),
    .seq_o    (frm_seq),
    .rst_o    (frm_rst)
  );

  sc_phase_acc #(.WORD_W(WORD_W), .INC_W(INC_W)) u_acc (
    .clk_i       (clk),
    .rst_ni      (rst_sync_n),
    .lock_en_i   (lock_en),
    .pal_i       (pal_mode),
    .tune_word_i (tune_word),
    .frm_done_i  (frm_done),
    .frm_inc_i   (frm_inc),
    .frm_seq_i   (frm_seq),
    .frm_rst_i   (frm_rst),
    .phase_o     (phase),
    .line_inv_o  (line_inv)
  );
endmodule

// File: tb/test_sc_phase_synth.sv
module test_sc_phase_synth;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        lock_en = 1'b0;
  logic        pal_mode = 1'b0;
  logic        lk_start = 1'b0;
  logic        lk_valid = 1'b0;
  logic        lk_bit = 1'b0;
  logic [31:0] phase;
  logic        line_inv;

  int errors = 0;
  int checks = 0;
  string cur_req = "R1";

  // reference model state
  int          m_exp;
  logic [7:0]  m_st [3];
  logic [31:0] m_comm;
  logic        m_busy;
  int          m_cnt;
  logic [31:0] m_sh;
  logic        m_done, m_seq, m_rst, m_ok, m_inv;
  logic [21:0] m_inc, m_linc;
  logic [31:0] m_phase;

  always #4 clk = ~clk;

  sc_phase_synth i_sc_phase_synth (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .lock_en(lock_en), .pal_mode(pal_mode), .lk_start(lk_start), .lk_valid(lk_valid),
    .lk_bit(lk_bit), .phase(phase), .line_inv(line_inv)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [32:0] build_frame(logic [21:0] inc, logic seq, logic rf,
                                              logic [3:0] sa, logic [4:0] sb);
    return {sa, inc, seq, rf, sb};
  endfunction

  task automatic model_reset();
    m_exp = 0; m_st[0] = '0; m_st[1] = '0; m_st[2] = '0;
    m_comm = 32'h21F07C1F; m_busy = 0; m_cnt = 0; m_sh = '0;
    m_done = 0; m_seq = 0; m_rst = 0; m_ok = 0; m_inv = 0;
    m_inc = '0; m_linc = '0; m_phase = '0;
  endtask

  task automatic model_edge();
    logic [31:0] word, n_phase, n_comm;
    logic [32:0] full;
    logic n_ok, n_inv, n_done, n_busy, n_seq, n_rst;
    logic [21:0] n_linc, n_inc;
    logic [31:0] n_sh;
    int n_cnt, n_exp;
    logic [7:0] n_st [3];
    bit hit;
    hit  = lock_en && m_done;
    word = m_comm;
    if (lock_en && (m_ok || m_done)) word = {(m_done ? m_inc : m_linc), m_comm[9:0]};
    n_phase = (hit && m_rst) ? 32'h0 : m_phase + word;
    n_inv   = (hit && pal_mode) ? m_seq : m_inv;
    n_ok    = lock_en && (m_ok || m_done);
    n_linc  = hit ? m_inc : m_linc;
    n_busy = m_busy; n_cnt = m_cnt; n_sh = m_sh; n_done = 0;
    n_inc = m_inc; n_seq = m_seq; n_rst = m_rst;
    if (!lock_en) n_busy = 0;
    else if (lk_start) begin n_busy = 1; n_cnt = 0; end
    else if (m_busy && lk_valid) begin
      full = {m_sh, lk_bit};
      if (m_cnt == 32) begin
        n_busy = 0; n_done = 1;
        n_inc = full[28:7]; n_seq = full[6]; n_rst = full[5];
      end else begin
        n_sh = full[31:0]; n_cnt = m_cnt + 1;
      end
    end
    n_exp = m_exp; n_comm = m_comm;
    for (int i = 0; i < 3; i++) n_st[i] = m_st[i];
    if (wr_en) begin
      if (int'(wr_addr) == m_exp) begin
        if (m_exp == 3) begin
          n_comm = {wr_data, m_st[2], m_st[1], m_st[0]}; n_exp = 0;
        end else begin
          n_st[m_exp] = wr_data; n_exp = m_exp + 1;
        end
      end else if (wr_addr == 2'd0) begin
        n_st[0] = wr_data; n_exp = 1;
      end else n_exp = 0;
    end
    m_phase = n_phase; m_inv = n_inv; m_ok = n_ok; m_linc = n_linc;
    m_busy = n_busy; m_cnt = n_cnt; m_sh = n_sh; m_done = n_done;
    m_inc = n_inc; m_seq = n_seq; m_rst = n_rst;
    m_exp = n_exp; m_comm = n_comm;
    for (int i = 0; i < 3; i++) m_st[i] = n_st[i];
  endtask

  task automatic cyc();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk(phase === m_phase, cur_req, phase, m_phase);
    chk(line_inv === m_inv, cur_req, {31'b0, line_inv}, {31'b0, m_inv});
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    cyc();
    wr_en = 0;
  endtask

  task automatic wr_word(input logic [31:0] w);
    for (int i = 0; i < 4; i++) wr(2'(i), w[i*8 +: 8]);
  endtask

  task automatic send_frame(input logic [21:0] inc, input logic seq, input logic rf,
                            input logic [3:0] sa, input logic [4:0] sb, input bit gaps);
    logic [32:0] f;
    f = build_frame(inc, seq, rf, sa, sb);
    lk_start = 1; lk_valid = 1; lk_bit = $urandom_range(0, 1);
    cyc();
    lk_start = 0;
    for (int i = 32; i >= 0; i--) begin
      if (gaps && ($urandom_range(0, 3) == 0)) begin
        lk_valid = 0; lk_bit = $urandom_range(0, 1); cyc();
      end
      lk_valid = 1; lk_bit = f[i];
      cyc();
    end
    lk_valid = 0;
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] p0, p1;
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk(phase === 32'h0, "R1", phase, 32'h0);
    chk(line_inv === 1'b0, "R1", {31'b0, line_inv}, 32'h0);
    cur_req = "R1";
    idle(5);
    chk(phase === 32'(5 * 32'h21F07C1F), "R1", phase, 32'(5 * 32'h21F07C1F));

    // R3: staged write, active only after byte 3
    cur_req = "R3";
    wr(2'd0, 8'hCB); idle(1); wr(2'd1, 8'h8A); wr(2'd2, 8'h09);
    p0 = phase; idle(1); p1 = phase;
    chk(p1 - p0 === 32'h21F07C1F, "R3", p1 - p0, 32'h21F07C1F);
    wr(2'd3, 8'h2A);
    p0 = phase; idle(1); p1 = phase;
    chk(p1 - p0 === 32'h2A098ACB, "R3", p1 - p0, 32'h2A098ACB);

    // R4: out-of-order writes
    cur_req = "R4";
    wr(2'd0, 8'h11); wr(2'd1, 8'h22); wr(2'd3, 8'h33);
    p0 = phase; idle(1); p1 = phase;
    chk(p1 - p0 === 32'h2A098ACB, "R4", p1 - p0, 32'h2A098ACB);
    wr(2'd2, 8'h44); wr(2'd0, 8'h55); wr(2'd0, 8'h01); wr(2'd1, 8'h02);
    wr(2'd2, 8'h03); wr(2'd3, 8'h04);
    p0 = phase; idle(1); p1 = phase;
    chk(p1 - p0 === 32'h04030201, "R4", p1 - p0, 32'h04030201);
    for (int k = 0; k < 300; k++) begin
      if ($urandom_range(0, 2) == 0) wr(2'($urandom_range(0, 3)), 8'($urandom));
      else idle(1);
    end

    // R2: random in-order words, wrap exercised by large steps
    cur_req = "R2";
    wr_word(32'hFFFF_FFF0);
    idle(4);
    for (int k = 0; k < 40; k++) begin
      wr_word($urandom);
      idle($urandom_range(0, 6));
    end

    // R5/R6/R9: lock frames in PAL
    lock_en = 1; pal_mode = 1;
    cur_req = "R5";
    send_frame(22'h2AAAAA, 1'b1, 1'b0, 4'hF, 5'h1F, 1'b0);
    cur_req = "R6";
    idle(3);
    p0 = phase; idle(1); p1 = phase;
    chk(p1 - p0 === {22'h2AAAAA, m_comm[9:0]}, "R6", p1 - p0, {22'h2AAAAA, m_comm[9:0]});
    chk(line_inv === 1'b1, "R8", {31'b0, line_inv}, 32'h1);
    cur_req = "R9";
    for (int k = 0; k < 12; k++) begin
      send_frame(22'($urandom), 1'($urandom), 1'b0, 4'($urandom), 5'($urandom), 1'b1);
      idle($urandom_range(1, 4));
    end

    // R7: reset flag clears phase on the edge after the last bit
    cur_req = "R7";
    send_frame(22'h155555, 1'b0, 1'b1, 4'h0, 5'h0, 1'b1);
    idle(1);
    chk(phase === 32'h0, "R7", phase, 32'h0);
    chk(line_inv === 1'b0, "R8", {31'b0, line_inv}, 32'h0);
    idle(3);

    // R8: NTSC holds the inversion flag
    cur_req = "R8";
    send_frame(22'h000100, 1'b1, 1'b0, 4'h3, 5'h3, 1'b0);
    idle(2);
    pal_mode = 0;
    send_frame(22'h000200, 1'b0, 1'b0, 4'h0, 5'h0, 1'b0);
    idle(2);
    chk(line_inv === 1'b1, "R8", {31'b0, line_inv}, 32'h1);
    pal_mode = 1;

    // same-cycle: byte-3 commit on the edge where a new increment is first used
    cur_req = "R6";
    for (int k = 0; k < 6; k++) begin
      wr(2'd0, 8'($urandom)); wr(2'd1, 8'($urandom)); wr(2'd2, 8'($urandom));
      send_frame(22'($urandom), 1'($urandom), 1'(k % 2), 4'($urandom), 5'($urandom), 1'b1);
      wr(2'd3, 8'($urandom));
      idle(3);
    end

    // R10: truncated frame, frames while off, leaving lock mode
    cur_req = "R10";
    lk_start = 1; cyc(); lk_start = 0;
    for (int i = 0; i < 20; i++) begin lk_valid = 1; lk_bit = 1'b1; cyc(); end
    lk_valid = 0;
    send_frame(22'h0ABCDE, 1'b0, 1'b0, 4'h0, 5'h0, 1'b0);
    idle(2);
    p0 = phase; idle(1); p1 = phase;
    chk(p1 - p0 === {22'h0ABCDE, m_comm[9:0]}, "R10", p1 - p0, {22'h0ABCDE, m_comm[9:0]});
    lock_en = 0;
    send_frame(22'h3FFFFF, 1'b1, 1'b1, 4'h0, 5'h0, 1'b0);
    idle(2);
    p0 = phase; idle(1); p1 = phase;
    chk(p1 - p0 === m_comm, "R10", p1 - p0, m_comm);
    chk(phase !== 32'h0 || m_phase === 32'h0, "R10", phase, m_phase);

    // mixed random traffic
    cur_req = "R2";
    for (int k = 0; k < 60; k++) begin
      lock_en  = 1'($urandom);
      pal_mode = 1'($urandom);
      case ($urandom_range(0, 2))
        0: send_frame(22'($urandom), 1'($urandom), 1'($urandom_range(0, 3) == 0),
                      4'($urandom), 5'($urandom), 1'b1);
        1: wr_word($urandom);
        default: idle($urandom_range(1, 8));
      endcase
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule